// File: doc/BRIEF.md
# Capture-Compare Interval Timer

This block is a 32-bit interval timer with a small synchronous register bus. Software uses it as an event timer or as a free-running time base. A single up-counter advances on every clock, or on every 2^(p+1) clocks when the prescaler is on. When the counter passes all ones it wraps. The wrap raises an overflow flag, and the counter restarts from zero or from a reload value. A comparator raises a flag when the count meets a programmable match value. An input-capture unit synchronises an external pin, detects a chosen edge on it, and latches the running count.

Each event sets a sticky flag. Software reads the flags in two views: unfiltered, and filtered by a per-flag enable. It clears a flag by writing a one to the filtered view. Enables are changed only through write-one set and write-one clear registers. The interrupt output goes high while any enabled flag is pending. A soft-reset command returns every register to its reset state over a short, observable busy window.

All accesses use a word index on `busAddr`. A write takes effect at the clock edge on which `busWrEn` is high. Read data is combinational from the current index.

Top module: `cc_interval_timer`

## Requirements
- R1: After `rstN` is released, the control (index 0), count (1), reload (2), match (3), capture (4), raw status (5) and enable (7) registers all read zero, and `irq` is low.
- R2: While control bit 0 (run) is set and the prescaler is off, the count rises by one per clock. While run is clear, the count holds.
- R3: When the count advances from all ones with control bit 1 (autoreload) clear, it becomes zero and status bit 0 (overflow) is set.
- R4: When the count advances from all ones with autoreload set, it takes the reload register value and sets status bit 0.
- R5: Control bit 2 enables the prescaler, and control bits 5:3 hold its value p. With the prescaler enabled, the count advances once every 2^(p+1) clocks.
- R6: A write to index 1 loads the count directly. A write of any value to index 9 copies the reload register into the count.
- R7: With control bit 6 (compare) set, status bit 1 (match) is set one clock after the count first equals the match register. It is set once per equality, even if the equality persists.
- R8: Control bits 8:7 pick the capture edge: 00 none, 01 rising, 10 falling, 11 both. The pin passes two synchronising flops. On the chosen edge, the capture register (index 4) takes the count present two clocks after the pin change, and status bit 2 is set.
- R9: Raw status (index 5) shows all flags whatever the enables. Masked status (index 6) reads raw AND enable. Writing 1s to index 6 clears those flags. Writes to index 5 have no effect.
- R10: Writing 1s to index 7 sets enable bits, and writing 1s to index 8 clears them. Zero bits change nothing. Both indices read back the enable register.
- R11: `irq` is high exactly when some flag is set together with its enable.
- R12: Writing 1 to bit 0 of index 10 starts a soft reset. Bit 0 of index 10 then reads 1 for SRST_CYCLES clocks. While that bit reads 1, bus writes are ignored. Afterwards, all registers hold their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and timer |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for the current index |
| busAddr | input | 4 | Register word index |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data |
| capPin | input | 1 | External capture input, asynchronous |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest situations to reach from the ports involve exact cycle positions. The first is capturing a count while the counter is moving. The stimulus reads the count on a falling clock edge, raises the pin in the same half cycle, and expects exactly that value plus two in the capture register. The second is the once-per-equality rule. Reaching it needs a stopped counter parked on the match value, so the equality persists while the flag is cleared and watched. The third is the soft-reset window. Here a write is issued while the busy bit is up, and the bench shows that the write left no trace.

// File: rtl/ccit_pkg.sv
package ccit_pkg;
  localparam int IDX_W  = 4;
  localparam int PS_W   = 3;
  localparam int DIV_W  = 1 << PS_W;
  localparam int CTRL_W = 9;
  localparam int FLAG_N = 3;

  localparam int FLAG_OVF   = 0;
  localparam int FLAG_MATCH = 1;
  localparam int FLAG_CAP   = 2;

  localparam int CB_RUN  = 0;
  localparam int CB_AUTO = 1;
  localparam int CB_PSEN = 2;
  localparam int CB_PS   = 3;
  localparam int CB_CMP  = 6;
  localparam int CB_EDGE = 7;

  typedef logic [IDX_W-1:0] ridx_t;
  localparam ridx_t RI_CTRL  = 4'd0;
  localparam ridx_t RI_COUNT = 4'd1;
  localparam ridx_t RI_LOAD  = 4'd2;
  localparam ridx_t RI_MATCH = 4'd3;
  localparam ridx_t RI_CAPT  = 4'd4;
  localparam ridx_t RI_RAW   = 4'd5;
  localparam ridx_t RI_MASK  = 4'd6;
  localparam ridx_t RI_ENSET = 4'd7;
  localparam ridx_t RI_ENCLR = 4'd8;
  localparam ridx_t RI_TRIG  = 4'd9;
  localparam ridx_t RI_SRST  = 4'd10;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_e;

  typedef struct packed {
    logic            run;
    logic            autoReload;
    logic            psEn;
    logic [PS_W-1:0] psVal;
    logic            cmpEn;
    edge_e           edgeSel;
  } cfg_t;

  typedef struct packed {
    logic cntWrite;
    logic reload;
    logic softClr;
  } strobe_t;

  // bit order matches the status flag positions: cap=2, match=1, ovf=0
  typedef struct packed {
    logic cap;
    logic match;
    logic ovf;
  } evt_t;
endpackage

// File: rtl/ccit_datapath.sv
module ccit_datapath
  import ccit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] matchVal,
  input  logic             capPin,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capVal,
  output evt_t             evt
);
  logic [DIV_W-1:0] psCnt;
  logic [DIV_W:0]   psSpan;
  logic [DIV_W-1:0] psLimit;
  logic             psWrap;
  logic             tick;
  logic             busLoad;
  logic             incr;
  logic             allOnes;
  logic             eqNow;
  logic             eqPrev;
  logic [1:0]       capSync;
  logic             capPrev;
  logic             riseEdge;
  logic             fallEdge;
  logic             edgeHit;

  // prescaler: terminal count 2^(p+1)-1
  assign psSpan  = (DIV_W+1)'(2) << cfg.psVal;
  assign psLimit = DIV_W'(psSpan - 1'b1);
  assign psWrap  = (psCnt == psLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (stb.softClr || !cfg.run || !cfg.psEn || stb.cntWrite || stb.reload || psWrap) begin
      psCnt <= '0;
    end else begin
      psCnt <= psCnt + 1'b1;
    end
  end

  assign tick    = cfg.run && (!cfg.psEn || psWrap);
  assign busLoad = stb.cntWrite || stb.reload;
  assign incr    = tick && !busLoad && !stb.softClr;
  assign allOnes = &count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (stb.softClr) begin
      count <= '0;
    end else if (stb.cntWrite) begin
      count <= wrData;
    end else if (stb.reload) begin
      count <= loadVal;
    end else if (incr) begin
      if (allOnes) count <= cfg.autoReload ? loadVal : '0;
      else         count <= count + 1'b1;
    end
  end

  // compare: flag on the first cycle of each equality
  assign eqNow = cfg.cmpEn && (count == matchVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            eqPrev <= 1'b0;
    else if (stb.softClr) eqPrev <= 1'b0;
    else                  eqPrev <= eqNow;
  end

  // capture input: two-flop synchroniser, then edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSync <= '0;
      capPrev <= 1'b0;
    end else begin
      capSync <= {capSync[0], capPin};
      capPrev <= capSync[1];
    end
  end

  assign riseEdge = capSync[1] && !capPrev;
  assign fallEdge = !capSync[1] && capPrev;

  always_comb begin
    unique case (cfg.edgeSel)
      EDGE_RISE: edgeHit = riseEdge;
      EDGE_FALL: edgeHit = fallEdge;
      EDGE_ANY:  edgeHit = riseEdge || fallEdge;
      default:   edgeHit = 1'b0;
    endcase
  end

  always_comb begin
    evt.ovf   = incr && allOnes;
    evt.match = eqNow && !eqPrev && !stb.softClr;
    evt.cap   = edgeHit && !stb.softClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            capVal <= '0;
    else if (stb.softClr) capVal <= '0;
    else if (evt.cap)     capVal <= count;
  end

  // R3: plain wrap lands on zero
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evt.ovf && !cfg.autoReload) |=> (count == '0));

  // R4: autoreload wrap lands on the reload value
  assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (evt.ovf && cfg.autoReload) |=> (count == $past(loadVal)));

  // R8: capture register holds the count seen at the edge
  assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    evt.cap |=> (capVal == $past(count)));
endmodule

// File: rtl/ccit_ctrl.sv
module ccit_ctrl
  import ccit_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  ridx_t             regIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] capVal,
  input  evt_t              evt,
  output cfg_t              cfg,
  output strobe_t           stb,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] matchVal,
  output logic              irq
);
  localparam int SR_W = $clog2(SRST_CYCLES + 1);

  logic [CTRL_W-1:0] ctrlReg;
  logic [FLAG_N-1:0] rawStat;
  logic [FLAG_N-1:0] enReg;
  logic [FLAG_N-1:0] evtBits;
  logic [SR_W-1:0]   srCnt;
  logic              srBusy;
  logic              wrOk;

  assign srBusy  = (srCnt != '0);
  assign wrOk    = wrEn && !srBusy;
  assign evtBits = evt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      srCnt <= '0;
    else if (wrOk && regIdx == RI_SRST && wrData[0])
      srCnt <= SR_W'(SRST_CYCLES);
    else if (srBusy)
      srCnt <= srCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      loadVal  <= '0;
      matchVal <= '0;
    end else if (srBusy) begin
      ctrlReg  <= '0;
      loadVal  <= '0;
      matchVal <= '0;
    end else if (wrOk) begin
      if (regIdx == RI_CTRL)  ctrlReg  <= wrData[CTRL_W-1:0];
      if (regIdx == RI_LOAD)  loadVal  <= wrData;
      if (regIdx == RI_MATCH) matchVal <= wrData;
    end
  end

  always_comb begin
    cfg.run        = ctrlReg[CB_RUN];
    cfg.autoReload = ctrlReg[CB_AUTO];
    cfg.psEn       = ctrlReg[CB_PSEN];
    cfg.psVal      = ctrlReg[CB_PS +: PS_W];
    cfg.cmpEn      = ctrlReg[CB_CMP];
    cfg.edgeSel    = edge_e'(ctrlReg[CB_EDGE +: 2]);
    stb.cntWrite   = wrOk && (regIdx == RI_COUNT);
    stb.reload     = wrOk && (regIdx == RI_TRIG);
    stb.softClr    = srBusy;
  end

  // one sticky flag and one enable per event source
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          rawStat[i] <= 1'b0;
      else if (srBusy)                                    rawStat[i] <= 1'b0;
      else if (evtBits[i])                                rawStat[i] <= 1'b1;
      else if (wrOk && regIdx == RI_MASK && wrData[i])    rawStat[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          enReg[i] <= 1'b0;
      else if (srBusy)                                    enReg[i] <= 1'b0;
      else if (wrOk && regIdx == RI_ENSET && wrData[i])   enReg[i] <= 1'b1;
      else if (wrOk && regIdx == RI_ENCLR && wrData[i])   enReg[i] <= 1'b0;
    end
  end

  assign irq = |(rawStat & enReg);

  always_comb begin
    unique case (regIdx)
      RI_CTRL:  rdData = DATA_W'(ctrlReg);
      RI_COUNT: rdData = count;
      RI_LOAD:  rdData = loadVal;
      RI_MATCH: rdData = matchVal;
      RI_CAPT:  rdData = capVal;
      RI_RAW:   rdData = DATA_W'(rawStat);
      RI_MASK:  rdData = DATA_W'(rawStat & enReg);
      RI_ENSET,
      RI_ENCLR: rdData = DATA_W'(enReg);
      RI_SRST:  rdData = DATA_W'(srBusy);
      default:  rdData = '0;
    endcase
  end

  // R3 R7 R8: every event leaves its flag set on the next cycle
  assert_flag_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((|evtBits) && !srBusy) |=> ((rawStat & $past(evtBits)) == $past(evtBits)));

  // R9: write-one to the masked view clears the flags it names
  assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && regIdx == RI_MASK && !(|evtBits)) |=> ((rawStat & $past(wrData[FLAG_N-1:0])) == '0));

  // R10: write-one set turns the named enables on
  assert_enable_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && regIdx == RI_ENSET) |=> ((enReg & $past(wrData[FLAG_N-1:0])) == $past(wrData[FLAG_N-1:0])));

  // R12: soft-reset command raises busy
  assert_srst_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && regIdx == RI_SRST && wrData[0]) |=> srBusy);
endmodule

// File: rtl/cc_interval_timer.sv
module cc_interval_timer
  import ccit_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [IDX_W-1:0]  busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              capPin,
  output logic              irq
);
  cfg_t              cfg;
  strobe_t           stb;
  evt_t              evt;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] capVal;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] matchVal;

  ccit_ctrl #(
    .DATA_W      (DATA_W),
    .SRST_CYCLES (SRST_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (busWrEn),
    .regIdx   (busAddr),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .count    (count),
    .capVal   (capVal),
    .evt      (evt),
    .cfg      (cfg),
    .stb      (stb),
    .loadVal  (loadVal),
    .matchVal (matchVal),
    .irq      (irq)
  );

  ccit_datapath #(
    .CNT_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .stb      (stb),
    .wrData   (busWrData),
    .loadVal  (loadVal),
    .matchVal (matchVal),
    .capPin   (capPin),
    .count    (count),
    .capVal   (capVal),
    .evt      (evt)
  );
endmodule

// File: tb/tb_cc_interval_timer.sv
module tb_cc_interval_timer;
  localparam logic [3:0] A_CTRL = 4'd0, A_COUNT = 4'd1, A_LOAD = 4'd2, A_MATCH = 4'd3,
                         A_CAPT = 4'd4, A_RAW = 4'd5, A_MASK = 4'd6, A_ENSET = 4'd7,
                         A_ENCLR = 4'd8, A_TRIG = 4'd9, A_SRST = 4'd10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        capPin = 1'b0;
  logic        irq;
  int          compared = 0;
  int          mismatched = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  cc_interval_timer dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .capPin(capPin), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called between a falling and the next rising edge; returns on the falling edge after the write
  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic expectReg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    expectReg("R1 ctrl", A_CTRL, 0);
    expectReg("R1 count", A_COUNT, 0);
    expectReg("R1 load", A_LOAD, 0);
    expectReg("R1 match", A_MATCH, 0);
    expectReg("R1 capture", A_CAPT, 0);
    expectReg("R1 raw", A_RAW, 0);
    expectReg("R1 enable", A_ENSET, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic testRun();
    logic [31:0] c0, c1;
    busWrite(A_COUNT, 100);
    expectReg("R6 direct count write", A_COUNT, 100);
    busWrite(A_CTRL, 32'h1);
    busRead(A_COUNT, c0);
    waitCycles(10);
    busRead(A_COUNT, c1);
    check("R2 rate", c1 - c0, 10);
    busWrite(A_CTRL, 0);
    busRead(A_COUNT, c0);
    waitCycles(5);
    busRead(A_COUNT, c1);
    check("R2 hold when stopped", c1 - c0, 0);
  endtask

  task automatic testOverflow();
    busWrite(A_COUNT, 32'hFFFF_FFFD);
    busWrite(A_ENSET, 32'h1);
    busWrite(A_CTRL, 32'h1);
    waitCycles(2);
    expectReg("R3 no flag before wrap", A_RAW, 0);
    expectReg("R3 at all ones", A_COUNT, 32'hFFFF_FFFF);
    waitCycles(1);
    expectReg("R3 wrap to zero", A_COUNT, 0);
    expectReg("R3 overflow flag", A_RAW, 1);
    check("R11 irq on enabled flag", 32'(irq), 1);
    busWrite(A_CTRL, 0);
    busWrite(A_RAW, 32'h7);
    expectReg("R9 raw write ignored", A_RAW, 1);
    busWrite(A_MASK, 0);
    expectReg("R9 zero clear ignored", A_RAW, 1);
    busWrite(A_MASK, 32'h1);
    expectReg("R9 w1 clears", A_RAW, 0);
    check("R11 irq drops", 32'(irq), 0);
    busWrite(A_ENCLR, 32'h7);
  endtask

  task automatic testAutoReload();
    busWrite(A_LOAD, 32'hFFFF_FFF0);
    busWrite(A_COUNT, 32'hFFFF_FFFE);
    busWrite(A_CTRL, 32'h3);
    waitCycles(1);
    expectReg("R4 at all ones", A_COUNT, 32'hFFFF_FFFF);
    waitCycles(1);
    expectReg("R4 reload on wrap", A_COUNT, 32'hFFFF_FFF0);
    expectReg("R4 overflow flag", A_RAW, 1);
    busWrite(A_CTRL, 0);
    busWrite(A_MASK, 32'h7);
  endtask

  task automatic testTrigger();
    busWrite(A_LOAD, 32'h0000_1234);
    busWrite(A_TRIG, 32'hDEAD_0000);
    expectReg("R6 trigger reload", A_COUNT, 32'h0000_1234);
  endtask

  task automatic testPrescale();
    logic [31:0] c0, c1;
    for (int p = 0; p < 3; p++) begin
      busWrite(A_CTRL, 0);
      busWrite(A_COUNT, 0);
      busWrite(A_CTRL, 32'h1 | 32'h4 | (32'(p) << 3));
      busRead(A_COUNT, c0);
      waitCycles(48);
      busRead(A_COUNT, c1);
      check($sformatf("R5 prescale p=%0d", p), c1 - c0, 32'(48 >> (p + 1)));
    end
    busWrite(A_CTRL, 0);
  endtask

  task automatic testMatch();
    busWrite(A_MASK, 32'h7);
    busWrite(A_MATCH, 20);
    busWrite(A_COUNT, 10);
    busWrite(A_ENSET, 32'h2);
    busWrite(A_CTRL, 32'h41);
    waitCycles(10);
    expectReg("R7 not yet", A_RAW, 0);
    waitCycles(1);
    expectReg("R7 match flag", A_RAW, 2);
    check("R11 irq match", 32'(irq), 1);
    busWrite(A_MASK, 32'h2);
    waitCycles(5);
    expectReg("R7 once while running", A_RAW, 0);
    busWrite(A_CTRL, 32'h40);
    busWrite(A_COUNT, 20);
    waitCycles(1);
    expectReg("R7 stopped equality", A_RAW, 2);
    busWrite(A_MASK, 32'h2);
    waitCycles(5);
    expectReg("R7 once per equality", A_RAW, 0);
    busWrite(A_CTRL, 0);
    busWrite(A_MATCH, 7);
    busWrite(A_COUNT, 5);
    busWrite(A_CTRL, 32'h1);
    waitCycles(10);
    expectReg("R7 compare disabled", A_RAW, 0);
    busWrite(A_CTRL, 0);
    busWrite(A_ENCLR, 32'h7);
  endtask

  task automatic pinTo(input logic v);
    capPin = v;
    waitCycles(4);
  endtask

  task automatic testCapture();
    logic [31:0] c;
    busWrite(A_COUNT, 32'h500);
    busWrite(A_CTRL, 32'h080);
    capPin = 1'b1;
    waitCycles(3);
    expectReg("R8 rise flag", A_RAW, 4);
    expectReg("R8 captured count", A_CAPT, 32'h500);
    busWrite(A_MASK, 32'h4);
    pinTo(1'b0);
    expectReg("R8 fall ignored in rise mode", A_RAW, 0);
    busWrite(A_CTRL, 32'h100);
    pinTo(1'b1);
    expectReg("R8 rise ignored in fall mode", A_RAW, 0);
    pinTo(1'b0);
    expectReg("R8 fall flag", A_RAW, 4);
    busWrite(A_MASK, 32'h4);
    busWrite(A_CTRL, 32'h000);
    pinTo(1'b1);
    pinTo(1'b0);
    expectReg("R8 none mode", A_RAW, 0);
    busWrite(A_CTRL, 32'h180);
    pinTo(1'b1);
    expectReg("R8 both rise", A_RAW, 4);
    busWrite(A_MASK, 32'h4);
    pinTo(1'b0);
    expectReg("R8 both fall", A_RAW, 4);
    busWrite(A_MASK, 32'h4);
    busWrite(A_CTRL, 32'h081);
    busRead(A_COUNT, c);
    capPin = 1'b1;
    waitCycles(3);
    expectReg("R8 running capture", A_CAPT, c + 2);
    busWrite(A_CTRL, 0);
    pinTo(1'b0);
    busWrite(A_MASK, 32'h7);
  endtask

  task automatic testEnables();
    busWrite(A_ENCLR, 32'h7);
    busWrite(A_COUNT, 32'hFFFF_FFFF);
    busWrite(A_CTRL, 32'h1);
    busWrite(A_CTRL, 0);
    expectReg("R9 raw without enable", A_RAW, 1);
    expectReg("R9 masked hides", A_MASK, 0);
    check("R11 irq masked", 32'(irq), 0);
    busWrite(A_ENSET, 32'h5);
    expectReg("R10 set", A_ENSET, 5);
    expectReg("R9 masked shows", A_MASK, 1);
    check("R11 irq enabled", 32'(irq), 1);
    busWrite(A_ENSET, 0);
    expectReg("R10 zero set", A_ENSET, 5);
    busWrite(A_ENCLR, 0);
    expectReg("R10 zero clear", A_ENCLR, 5);
    busWrite(A_ENCLR, 32'h1);
    expectReg("R10 clear", A_ENCLR, 4);
    check("R11 irq after disable", 32'(irq), 0);
    expectReg("R9 raw kept", A_RAW, 1);
    busWrite(A_MASK, 32'h1);
    expectReg("R9 clear while disabled", A_RAW, 0);
    busWrite(A_ENCLR, 32'h7);
  endtask

  task automatic testSoftReset();
    busWrite(A_CTRL, 32'h43);
    busWrite(A_ENSET, 32'h7);
    busWrite(A_LOAD, 32'h99);
    busWrite(A_COUNT, 32'h1000);
    busWrite(A_SRST, 32'h1);
    expectReg("R12 busy", A_SRST, 1);
    busWrite(A_CTRL, 32'h1);
    waitCycles(2);
    expectReg("R12 still busy", A_SRST, 1);
    waitCycles(1);
    expectReg("R12 busy ends", A_SRST, 0);
    waitCycles(1);
    expectReg("R12 ctrl cleared, write ignored", A_CTRL, 0);
    expectReg("R12 count cleared", A_COUNT, 0);
    expectReg("R12 load cleared", A_LOAD, 0);
    expectReg("R12 enable cleared", A_ENSET, 0);
    expectReg("R12 raw cleared", A_RAW, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRun();
    testOverflow();
    testAutoReload();
    testTrigger();
    testPrescale();
    testMatch();
    testCapture();
    testEnables();
    testSoftReset();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule